// File: doc/BRIEF.md
# Interrupt Enable and Control Unit

This block keeps the interrupt-enable state of a small 16-bit processor core and the registers that steer interrupt handling. Two enable flags are held: a primary flag that gates every maskable request, and a shadow flag that preserves the primary flag across a non-maskable interrupt so the special return can restore it. The core reports its interrupt-related operations to the block on a 3-bit operation code, one per cycle. The block tells the core which maskable line to service, and whether a non-maskable event is pending, over two valid/ready outputs.

A maskable request is offered on `irq_valid`/`irq_id`. The request is taken in a cycle where `irq_valid` and `irq_ready` are both high. While `irq_ready` is low, `irq_valid` stays asserted for as long as the gated request lines stay active. `irq_id` always names the highest-priority active gated line, so a higher-priority line that arrives during back-pressure replaces the offered identifier. The non-maskable request is offered on `nmi_valid`. It is taken in a cycle where `nmi_valid` and `nmi_ready` are both high, and stays offered without change until it is taken.

The block also holds a 16-bit interrupt vector register, which can be accessed as a low byte or as a full word. Three 8-bit registers sit in on-chip I/O space: a per-line enable mask, a vector base and a trap/break status register. Instruction decode, vector fetch and stack handling belong to the core.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset both enable flags are 0, the vector register, mask, vector base and trap/break register are 0, and neither `irq_valid` nor `nmi_valid` is asserted.
- R2: Operation code 1 (enable) sets both flags to 1, and code 2 (disable) clears both flags. The new values are visible on the cycle after the operation.
- R3: When a non-maskable request is taken, the shadow flag receives the old primary flag and the primary flag becomes 0.
- R4: Code 3 (non-maskable return) copies the shadow flag into the primary flag. Code 4 (ordinary return) and code 0 (none) leave both flags unchanged.
- R5: Taking a maskable request clears the primary flag and leaves the shadow flag unchanged. Code 5 (trap) has the same effect on the flags and also sets bit 0 of the trap/break register; a trap in the same cycle as a write to that register wins for bit 0.
- R6: When a request is taken in the same cycle as an enable, disable or non-maskable return, the take decides the flags and the operation code is ignored. If both kinds of request are taken together, the non-maskable rule applies.
- R7: `irq_valid` is 1 only when the primary flag is 1 and some line has both its request and its mask bit at 1. `irq_id` is the lowest such line index. The offer is held while `irq_ready` is low.
- R8: A rising edge on `nmi_in` makes `nmi_valid` 1 on the next cycle, whatever the enable flags are. `nmi_valid` stays 1 until it is taken. A steady high level on `nmi_in` produces no further request, and an edge that arrives in the same cycle as the take keeps the request pending.
- R9: Code 6 (read vector register) drives `pv_valid` to 1 on the next cycle, with `pv_flag` equal to the shadow flag as it was in the cycle of the operation.
- R10: A write to the vector register with `ireg_wide` at 1 stores all 16 bits; with `ireg_wide` at 0 only bits 7:0 change. A read with `ireg_rd_wide` at 0 returns bits 7:0 zero-extended.
- R11: I/O address 0x17 maps the mask (bits 3:0, upper bits read 0), 0x18 the vector base and 0x19 the trap/break register. Reads are combinational. Writes to any other address are ignored, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code for this cycle |
| irq_in | input | 4 | Maskable request lines, level sensitive |
| irq_valid | output | 1 | Maskable request offered |
| irq_ready | input | 1 | Core takes the maskable request |
| irq_id | output | 2 | Index of the offered line |
| nmi_in | input | 1 | Non-maskable request input, edge detected |
| nmi_valid | output | 1 | Non-maskable request pending |
| nmi_ready | input | 1 | Core takes the non-maskable request |
| en_primary | output | 1 | Primary enable flag |
| en_shadow | output | 1 | Shadow enable flag |
| pv_valid | output | 1 | Status flag result valid |
| pv_flag | output | 1 | Shadow flag reported for a vector-register read |
| ireg_we | input | 1 | Vector register write strobe |
| ireg_wide | input | 1 | Write is 16 bits (1) or low byte (0) |
| ireg_wdata | input | 16 | Vector register write data |
| ireg_rd_wide | input | 1 | Read is 16 bits (1) or low byte (0) |
| ireg_rdata | output | 16 | Vector register read data |
| io_addr | input | 8 | On-chip I/O address |
| io_we | input | 1 | On-chip I/O write strobe |
| io_wdata | input | 8 | On-chip I/O write data |
| io_rdata | output | 8 | On-chip I/O read data |

## Verification
Maskable requests are driven with the flags off, with the flags on and the mask open, and with the mask partly closed. Multi-line patterns such as 0110 and 1000 show whether the lowest gated index wins and whether the mask or the primary flag is the one that blocks. Back-pressure cycles with `irq_ready` low separate a held offer from a dropped one. Non-maskable requests are sent as pulses, as a held level and as an edge coinciding with a take, which separates true edge detection from level sensing. Enable, disable and return codes are issued alone and in the same cycle as takes, so the precedence rule shows in the flag values.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_EI   = 3'd1,
    OP_DI   = 3'd2,
    OP_RETN = 3'd3,
    OP_RETI = 3'd4,
    OP_TRAP = 3'd5,
    OP_RDI  = 3'd6
  } op_e;

  localparam logic [7:0] ADDR_MASK  = 8'h17;
  localparam logic [7:0] ADDR_VBASE = 8'h18;
  localparam logic [7:0] ADDR_TRAP  = 8'h19;
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op,
  input  logic nmi_fire,
  input  logic int_fire,
  output logic ief1,
  output logic ief2,
  output logic pv_valid,
  output logic pv_flag
);
  logic nxt1, nxt2;

  always_comb begin
    nxt1 = ief1;
    nxt2 = ief2;
    if (nmi_fire) begin
      nxt2 = ief1;
      nxt1 = 1'b0;
    end else if (int_fire) begin
      nxt1 = 1'b0;
    end else begin
      unique case (op)
        OP_EI:   begin nxt1 = 1'b1; nxt2 = 1'b1; end
        OP_DI:   begin nxt1 = 1'b0; nxt2 = 1'b0; end
        OP_RETN: nxt1 = ief2;
        OP_TRAP: nxt1 = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ief1     <= 1'b0;
      ief2     <= 1'b0;
      pv_valid <= 1'b0;
      pv_flag  <= 1'b0;
    end else begin
      ief1     <= nxt1;
      ief2     <= nxt2;
      pv_valid <= (op == OP_RDI);
      pv_flag  <= ief2;
    end
  end

  p_ei_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EI && !nmi_fire && !int_fire) |=> (ief1 && ief2));
  p_di_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DI && !nmi_fire && !int_fire) |=> (!ief1 && !ief2));
  p_nmi_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fire |=> (!ief1 && ief2 == $past(ief1)));
  p_retn_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RETN && !nmi_fire && !int_fire) |=> (ief1 == $past(ief2)));
  p_int_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fire && !nmi_fire) |=> (!ief1 && $stable(ief2)));
  p_pv_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RDI) |=> (pv_valid && pv_flag == $past(ief2)));
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_IRQ = 4,
  localparam int IDW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] mask,
  input  logic             ief1,
  input  logic             irq_ready,
  input  logic             nmi_in,
  input  logic             nmi_ready,
  output logic             irq_valid,
  output logic [IDW-1:0]   irq_id,
  output logic             int_fire,
  output logic             nmi_valid,
  output logic             nmi_fire
);
  logic [N_IRQ-1:0] gated;
  logic nmi_q, nmi_pend, nmi_rise;

  assign gated = ief1 ? (irq_in & mask) : '0;
  assign irq_valid = |gated;
  assign int_fire = irq_valid & irq_ready;

  always_comb begin
    irq_id = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (gated[i]) irq_id = IDW'(i);
    end
  end

  assign nmi_rise  = nmi_in & ~nmi_q;
  assign nmi_valid = nmi_pend;
  assign nmi_fire  = nmi_pend & nmi_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= nmi_rise | (nmi_pend & ~nmi_ready);
    end
  end

  p_blocked_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ief1 |-> !irq_valid);
  p_id_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_in[irq_id] && mask[irq_id]));
  p_nmi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_valid && !nmi_ready) |=> nmi_valid);
  p_nmi_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_in && !nmi_q) |=> nmi_valid);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctl_pkg::*;
#(
  parameter int N_IRQ   = 4,
  parameter int IREG_W  = 16,
  parameter int IREG_LO = 8,
  parameter int IO_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_evt,
  input  logic              ireg_we,
  input  logic              ireg_wide,
  input  logic [IREG_W-1:0] ireg_wdata,
  input  logic              ireg_rd_wide,
  output logic [IREG_W-1:0] ireg_rdata,
  input  logic [7:0]        io_addr,
  input  logic              io_we,
  input  logic [IO_W-1:0]   io_wdata,
  output logic [IO_W-1:0]   io_rdata,
  output logic [N_IRQ-1:0]  mask
);
  logic [IREG_W-1:0] ireg;
  logic [IO_W-1:0]   vbase, trapreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ireg    <= '0;
      mask    <= '0;
      vbase   <= '0;
      trapreg <= '0;
    end else begin
      if (ireg_we) begin
        if (ireg_wide) ireg <= ireg_wdata;
        else           ireg[IREG_LO-1:0] <= ireg_wdata[IREG_LO-1:0];
      end
      if (io_we) begin
        unique case (io_addr)
          ADDR_MASK:  mask    <= io_wdata[N_IRQ-1:0];
          ADDR_VBASE: vbase   <= io_wdata;
          ADDR_TRAP:  trapreg <= io_wdata;
          default: ;
        endcase
      end
      if (trap_evt) trapreg[0] <= 1'b1;
    end
  end

  assign ireg_rdata = ireg_rd_wide ? ireg
                    : {{(IREG_W-IREG_LO){1'b0}}, ireg[IREG_LO-1:0]};

  always_comb begin
    unique case (io_addr)
      ADDR_MASK:  io_rdata = IO_W'(mask);
      ADDR_VBASE: io_rdata = vbase;
      ADDR_TRAP:  io_rdata = trapreg;
      default:    io_rdata = '0;
    endcase
  end

  p_narrow_keeps_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ireg_we && !ireg_wide) |=> (ireg[IREG_W-1:IREG_LO] == $past(ireg[IREG_W-1:IREG_LO])));
  p_trap_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_evt |=> trapreg[0]);
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int N_IRQ   = 4,
  parameter int IREG_W  = 16,
  parameter int IREG_LO = 8,
  parameter int IO_W    = 8,
  localparam int IDW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [N_IRQ-1:0]  irq_in,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [IDW-1:0]    irq_id,
  input  logic              nmi_in,
  output logic              nmi_valid,
  input  logic              nmi_ready,
  output logic              en_primary,
  output logic              en_shadow,
  output logic              pv_valid,
  output logic              pv_flag,
  input  logic              ireg_we,
  input  logic              ireg_wide,
  input  logic [IREG_W-1:0] ireg_wdata,
  input  logic              ireg_rd_wide,
  output logic [IREG_W-1:0] ireg_rdata,
  input  logic [7:0]        io_addr,
  input  logic              io_we,
  input  logic [IO_W-1:0]   io_wdata,
  output logic [IO_W-1:0]   io_rdata
);
  op_e op_q;
  logic nmi_fire, int_fire;
  logic [N_IRQ-1:0] mask;

  assign op_q = op_e'(op);

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .op(op_q),
    .nmi_fire(nmi_fire), .int_fire(int_fire),
    .ief1(en_primary), .ief2(en_shadow),
    .pv_valid(pv_valid), .pv_flag(pv_flag)
  );

  irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask),
    .ief1(en_primary), .irq_ready(irq_ready),
    .nmi_in(nmi_in), .nmi_ready(nmi_ready),
    .irq_valid(irq_valid), .irq_id(irq_id), .int_fire(int_fire),
    .nmi_valid(nmi_valid), .nmi_fire(nmi_fire)
  );

  irq_regs #(.N_IRQ(N_IRQ), .IREG_W(IREG_W), .IREG_LO(IREG_LO), .IO_W(IO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .trap_evt(op_q == OP_TRAP),
    .ireg_we(ireg_we), .ireg_wide(ireg_wide), .ireg_wdata(ireg_wdata),
    .ireg_rd_wide(ireg_rd_wide), .ireg_rdata(ireg_rdata),
    .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mask(mask)
  );

  p_ack_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fire && op_q == OP_EI) |=> !en_primary);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!irq_valid && !nmi_valid));
endmodule

// File: tb/sim_irq_ctl_top.sv
module sim_irq_ctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [3:0] irq_in = 4'd0;
  logic irq_ready = 1'b0, nmi_in = 1'b0, nmi_ready = 1'b0;
  logic irq_valid, nmi_valid, en_primary, en_shadow, pv_valid, pv_flag;
  logic [1:0] irq_id;
  logic ireg_we = 1'b0, ireg_wide = 1'b0, ireg_rd_wide = 1'b0;
  logic [15:0] ireg_wdata = 16'd0, ireg_rdata;
  logic [7:0] io_addr = 8'd0, io_wdata = 8'd0, io_rdata;
  logic io_we = 1'b0;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  int m_f1, m_f2, m_pvv, m_pvf, m_ireg, m_mask, m_vb, m_trap, m_nq, m_np;

  always #4 clk = ~clk;

  irq_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .irq_in(irq_in),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id),
    .nmi_in(nmi_in), .nmi_valid(nmi_valid), .nmi_ready(nmi_ready),
    .en_primary(en_primary), .en_shadow(en_shadow),
    .pv_valid(pv_valid), .pv_flag(pv_flag),
    .ireg_we(ireg_we), .ireg_wide(ireg_wide), .ireg_wdata(ireg_wdata),
    .ireg_rd_wide(ireg_rd_wide), .ireg_rdata(ireg_rdata),
    .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_f1 = 0; m_f2 = 0; m_pvv = 0; m_pvf = 0; m_ireg = 0;
      m_mask = 0; m_vb = 0; m_trap = 0; m_nq = 0; m_np = 0;
    end else begin
      int f1, f2, ifire, nfire, rise;
      f1 = m_f1; f2 = m_f2;
      ifire = (m_f1 != 0 && (irq_in & m_mask[3:0]) != 0 && irq_ready) ? 1 : 0;
      nfire = (m_np != 0 && nmi_ready) ? 1 : 0;
      rise = (nmi_in && m_nq == 0) ? 1 : 0;
      if (nfire != 0) begin f2 = m_f1; f1 = 0; end
      else if (ifire != 0) f1 = 0;
      else if (op == 3'd1) begin f1 = 1; f2 = 1; end
      else if (op == 3'd2) begin f1 = 0; f2 = 0; end
      else if (op == 3'd3) f1 = m_f2;
      else if (op == 3'd5) f1 = 0;
      m_pvv = (op == 3'd6) ? 1 : 0;
      m_pvf = m_f2;
      m_f1 = f1; m_f2 = f2;
      if (ireg_we) m_ireg = ireg_wide ? int'(ireg_wdata) : ((m_ireg & 'hFF00) | int'(ireg_wdata[7:0]));
      if (io_we && io_addr == 8'h17) m_mask = int'(io_wdata[3:0]);
      if (io_we && io_addr == 8'h18) m_vb = int'(io_wdata);
      if (io_we && io_addr == 8'h19) m_trap = int'(io_wdata);
      if (op == 3'd5) m_trap = m_trap | 1;
      m_np = (rise != 0 || (m_np != 0 && !nmi_ready)) ? 1 : 0;
      m_nq = nmi_in ? 1 : 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int g, ev, eid, ird, iord;
      g = (m_f1 != 0) ? (irq_in & m_mask[3:0]) : 0;
      ev = (g != 0) ? 1 : 0;
      eid = 0;
      for (int i = 3; i >= 0; i--) if (g[i]) eid = i;
      ird = ireg_rd_wide ? m_ireg : (m_ireg & 'hFF);
      iord = (io_addr == 8'h17) ? m_mask : (io_addr == 8'h18) ? m_vb :
             (io_addr == 8'h19) ? m_trap : 0;
      chk("en_primary", int'(en_primary), m_f1);
      chk("en_shadow", int'(en_shadow), m_f2);
      chk("irq_valid", int'(irq_valid), ev);
      if (ev != 0) chk("irq_id", int'(irq_id), eid);
      chk("nmi_valid", int'(nmi_valid), m_np);
      chk("pv_valid", int'(pv_valid), m_pvv);
      if (m_pvv != 0) chk("pv_flag", int'(pv_flag), m_pvf);
      chk("ireg_rdata", int'(ireg_rdata), ird);
      chk("io_rdata", int'(io_rdata), iord);
    end
  end

  task automatic tick(string t, int n = 1);
    tag = t;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #6;
      op = 3'd0; io_we = 1'b0; ireg_we = 1'b0;
    end
  endtask

  task automatic io_write(string t, logic [7:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    tick(t);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #6 rst_n = 1'b1;
    // R1: reset state, all registers read back
    io_addr = 8'h17; tick("R1");
    io_addr = 8'h18; tick("R1");
    io_addr = 8'h19; ireg_rd_wide = 1'b1; tick("R1");
    // R10: wide then narrow writes
    ireg_we = 1'b1; ireg_wide = 1'b1; ireg_wdata = 16'hA55A; tick("R10");
    ireg_we = 1'b1; ireg_wide = 1'b0; ireg_wdata = 16'h1234; tick("R10");
    ireg_rd_wide = 1'b0; tick("R10");
    ireg_rd_wide = 1'b1; tick("R10");
    // R11: map and unmapped address
    io_write("R11", 8'h17, 8'hFF);
    io_write("R11", 8'h18, 8'h3C);
    io_write("R11", 8'h19, 8'h80);
    io_write("R11", 8'h20, 8'h55);
    io_addr = 8'h17; tick("R11");
    io_addr = 8'h20; tick("R11");
    // R7: flags off blocks requests
    irq_in = 4'b0110; tick("R7", 2);
    // R2: enable, then offer held under back-pressure
    op = 3'd1; tick("R2");
    tick("R7", 3);
    irq_in = 4'b0111; tick("R7");
    // R5: take the request
    irq_ready = 1'b1; tick("R5");
    irq_ready = 1'b0; irq_in = 4'b0000; tick("R5");
    // R7: mask partly closed
    op = 3'd1; tick("R2");
    io_write("R7", 8'h17, 8'h07);
    irq_in = 4'b1000; tick("R7", 2);
    io_write("R7", 8'h17, 8'h0F); tick("R7");
    irq_in = 4'b0000;
    // R9: read vector register reports shadow
    op = 3'd6; tick("R9"); tick("R9");
    // R8: edge, held without ready, enables off do not matter
    nmi_in = 1'b1; tick("R8"); nmi_in = 1'b0; tick("R8", 3);
    // R3: take nmi
    nmi_ready = 1'b1; tick("R3"); nmi_ready = 1'b0; tick("R3");
    op = 3'd6; tick("R9"); tick("R9");
    // R4: ordinary return leaves flags, special return restores
    op = 3'd4; tick("R4"); tick("R4");
    op = 3'd3; tick("R4"); tick("R4");
    // R8: held level gives one request only
    nmi_in = 1'b1; tick("R8", 2);
    nmi_ready = 1'b1; tick("R8"); nmi_ready = 1'b0; tick("R8", 3);
    nmi_in = 1'b0; tick("R8");
    // R8: edge coinciding with take keeps pending
    nmi_in = 1'b1; tick("R8"); nmi_in = 1'b0; tick("R8");
    nmi_ready = 1'b1; tick("R8");
    nmi_in = 1'b1; tick("R8");
    nmi_ready = 1'b0; nmi_in = 1'b0; tick("R8", 2);
    nmi_ready = 1'b1; tick("R8"); nmi_ready = 1'b0; tick("R8");
    // R6: enable in the same cycle as a maskable take
    op = 3'd1; tick("R6");
    irq_in = 4'b0010; irq_ready = 1'b1; op = 3'd1; tick("R6");
    irq_ready = 1'b0; irq_in = 4'b0000; tick("R6");
    // R6: disable in the same cycle as a non-maskable take
    op = 3'd1; tick("R6");
    nmi_in = 1'b1; tick("R6"); nmi_in = 1'b0;
    nmi_ready = 1'b1; op = 3'd2; tick("R6");
    nmi_ready = 1'b0; tick("R6");
    // R5: trap, and trap against a write to trap/break
    op = 3'd1; tick("R2");
    op = 3'd5; io_addr = 8'h19; tick("R5"); tick("R5");
    io_addr = 8'h19; io_wdata = 8'h40; io_we = 1'b1; op = 3'd5; tick("R5");
    tick("R5");
    // R2: disable
    op = 3'd2; tick("R2"); tick("R2");
    done = 1;
    summary();
  end
endmodule